// File: doc/BRIEF.md
# Pin-Event Timer Capture Unit

This block watches one external input pin and, when a selected kind of transition occurs on it, stores the current value of a 16-bit free-running timer into a capture register. Two timer buses come into the block, and a select bit in the control register decides which one is sampled. The pin is first passed through a synchroniser. Edge detection then runs in the core clock domain. The event can be every falling edge, every rising edge, every fourth rising edge or every sixteenth rising edge.

Each capture sets a sticky flag, which also drives the interrupt output. The flag stays set until software writes it back to zero. Software uses a small byte-wide register port to do three things: program the control register, read the captured value as a low byte and a high byte, and clear the flag. Nothing guards an unread capture, so a later event overwrites the stored value. The event depends only on the pin level, whatever drives it. If the pin is also driven as an output, toggling it from software therefore triggers captures in the same way.

Top module: `edge_capture_unit`

## Requirements
- R1: After reset, all four registers read as zero and `cap_irq` is low.
- R2: Suppose the pin changes while the timer word last loaded is T, before clock edge k+1. A qualifying change then loads the capture register at edge k+4 with the selected timer's value as it was just before that edge. With free-running timers this value is T+3.
- R3: Mode code 4'b0100 (control bits [3:0]) captures on every falling edge of the pin and ignores rising edges.
- R4: Mode code 4'b0101 captures on every rising edge of the pin and ignores falling edges.
- R5: Mode code 4'b0110 captures on every 4th rising edge and mode code 4'b0111 captures on every 16th rising edge. In both modes, fewer rising edges than that produce no capture.
- R6: Any write to the control register (address 0) resets the rising-edge count to zero. The count of 4 or 16 then starts again from that write.
- R7: Every mode code other than 4'b0100 to 4'b0111 disables capture. The capture register and flag stay untouched, whatever the pin does.
- R8: Control bit 4 selects the timer. 0 samples `tmr_a` and 1 samples `tmr_b`.
- R9: Each capture sets the flag, which is bit 0 at address 3, and `cap_irq` follows it. The flag stays set until software writes address 3. A write loads the flag from data bit 0, so writing 0 clears it. A capture in the same cycle as the write takes priority.
- R10: A second capture before software reads the register replaces the stored value. Only the newest value remains.
- R11: Address 1 (low byte) and address 2 (high byte) read the capture register and can also be written, which loads that byte directly. Address 0 reads back the control bits in the layout they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cap_pin | input | 1 | Asynchronous external event pin |
| tmr_a | input | 16 | First timer bus |
| tmr_b | input | 16 | Second timer bus |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 capture low, 2 capture high, 3 flag |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| cap_irq | output | 1 | Interrupt request, equal to the capture flag |

## Verification
The prescaled modes are checked at their boundaries. Three and fifteen rising edges must give no capture, and four and sixteen must give exactly one. A design that counted from one, or let the count continue across a control write, would capture one edge early or late, and the bench catches it. The capture value is predicted from the timer as it is being captured, so any extra or missing pipeline stage leaves an off-by-one value in the low byte. Two more corners are covered. Disabled codes, both below and above the valid range, must leave the register alone. The overwrite and timer-select paths must hold the latest value from the correct bus.

// File: rtl/ecap_pkg.sv
// Package: shared constants and helpers for the pin-event capture unit.
// Assumes a two-bit register address and four-bit mode codes.
package ecap_pkg;
    localparam logic [3:0] MODE_FALL    = 4'b0100;
    localparam logic [3:0] MODE_RISE    = 4'b0101;
    localparam logic [3:0] MODE_RISE_LO = 4'b0110;
    localparam logic [3:0] MODE_RISE_HI = 4'b0111;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_CAPL = 2'd1;
    localparam logic [1:0] ADDR_CAPH = 2'd2;
    localparam logic [1:0] ADDR_FLAG = 2'd3;

    // True when the mode code uses the rising-edge divider.
    function automatic logic mode_divided(input logic [3:0] m);
        return (m == MODE_RISE_LO) || (m == MODE_RISE_HI);
    endfunction
endpackage

// File: rtl/ecap_sync_edge.sv
// Module: brings the asynchronous pin into the clock domain through a
// flop chain and produces single-cycle rise and fall strobes.
// Assumes SYNC_STAGES >= 2 and a pin that is low when reset releases.
module ecap_sync_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] chain;
    logic                   prev;

    // Shift the pin through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[TOP-1:0], pin};
    end

    // Hold the previous synchronised level for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= chain[TOP];
    end

    // Edge strobes from current against previous level.
    always_comb begin
        rise = chain[TOP] & ~prev;
        fall = ~chain[TOP] & prev;
    end
endmodule

// File: rtl/ecap_prescale.sv
// Module: decodes the mode code, counts rising edges for the divided
// modes and registers a one-cycle capture event.
// Assumes DIV_HI >= DIV_LO >= 2; a mode write clears the count.
module ecap_prescale
    import ecap_pkg::*;
#(
    parameter int DIV_LO = 4,
    parameter int DIV_HI = 16,
    localparam int CNT_W = $clog2(DIV_HI)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       mode,
    input  logic             mode_wr,
    input  logic             rise,
    input  logic             fall,
    output logic             cap_evt,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] LAST_LO = CNT_W'(DIV_LO - 1);
    localparam logic [CNT_W-1:0] LAST_HI = CNT_W'(DIV_HI - 1);

    logic hit;
    logic wrap;

    // Decide whether this edge qualifies under the current mode.
    always_comb begin
        wrap = 1'b0;
        case (mode)
            MODE_FALL:    hit = fall;
            MODE_RISE:    hit = rise;
            MODE_RISE_LO: begin wrap = (cnt == LAST_LO); hit = rise & wrap; end
            MODE_RISE_HI: begin wrap = (cnt == LAST_HI); hit = rise & wrap; end
            default:      hit = 1'b0;
        endcase
    end

    // Count rising edges in divided modes; restart on mode writes.
    always_ff @(posedge clk) begin
        if (!rst_n)                        cnt <= '0;
        else if (mode_wr)                  cnt <= '0;
        else if (rise && mode_divided(mode)) cnt <= wrap ? '0 : cnt + 1'b1;
    end

    // Register the event so capture happens one cycle after detection.
    always_ff @(posedge clk) begin
        if (!rst_n) cap_evt <= 1'b0;
        else        cap_evt <= hit;
    end
endmodule

// File: rtl/ecap_regs.sv
// Module: control, capture and flag registers plus the byte read mux.
// Assumes TMR_W is exactly twice DATA_W; capture beats software writes.
module ecap_regs
    import ecap_pkg::*;
#(
    parameter int TMR_W  = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              cap_evt,
    input  logic [TMR_W-1:0]  tmr_a,
    input  logic [TMR_W-1:0]  tmr_b,
    output logic [3:0]        mode,
    output logic              tsel,
    output logic              mode_wr,
    output logic [TMR_W-1:0]  cap_val,
    output logic              flag,
    output logic [DATA_W-1:0] rdata
);
    localparam int HALF = TMR_W / 2;

    // Decode the control write strobe.
    always_comb mode_wr = wr && (addr == ADDR_CTRL);

    // Control register: mode code and timer select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= '0;
            tsel <= 1'b0;
        end else if (mode_wr) begin
            mode <= wdata[3:0];
            tsel <= wdata[4];
        end
    end

    // Capture register: event load wins over byte writes.
    always_ff @(posedge clk) begin
        if (!rst_n)                              cap_val <= '0;
        else if (cap_evt)                        cap_val <= tsel ? tmr_b : tmr_a;
        else if (wr && addr == ADDR_CAPL)        cap_val[HALF-1:0] <= wdata;
        else if (wr && addr == ADDR_CAPH)        cap_val[TMR_W-1:HALF] <= wdata;
    end

    // Sticky flag: set by capture, loaded by software otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)                       flag <= 1'b0;
        else if (cap_evt)                 flag <= 1'b1;
        else if (wr && addr == ADDR_FLAG) flag <= wdata[0];
    end

    // Read multiplexer over the four byte registers.
    always_comb begin
        case (addr)
            ADDR_CTRL: rdata = {{(DATA_W-5){1'b0}}, tsel, mode};
            ADDR_CAPL: rdata = cap_val[HALF-1:0];
            ADDR_CAPH: rdata = cap_val[TMR_W-1:HALF];
            default:   rdata = {{(DATA_W-1){1'b0}}, flag};
        endcase
    end
endmodule

// File: rtl/edge_capture_unit.sv
// Module: top of the pin-event timer capture unit. Chains synchroniser,
// event qualifier and register file; the interrupt mirrors the flag.
// Assumes timer buses are already in this clock domain.
module edge_capture_unit #(
    parameter int TMR_W       = 16,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int DIV_LO      = 4,
    parameter int DIV_HI      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_pin,
    input  logic [TMR_W-1:0]  tmr_a,
    input  logic [TMR_W-1:0]  tmr_b,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              cap_irq
);
    localparam int CNT_W = $clog2(DIV_HI);

    logic             pin_rise;
    logic             pin_fall;
    logic             cap_evt;
    logic [CNT_W-1:0] presc_cnt;
    logic [3:0]       mode;
    logic             tsel;
    logic             mode_wr;
    logic [TMR_W-1:0] cap_val;
    logic             flag;

    ecap_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin(cap_pin),
        .rise(pin_rise), .fall(pin_fall)
    );

    ecap_prescale #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_presc (
        .clk(clk), .rst_n(rst_n), .mode(mode), .mode_wr(mode_wr),
        .rise(pin_rise), .fall(pin_fall), .cap_evt(cap_evt), .cnt(presc_cnt)
    );

    ecap_regs #(.TMR_W(TMR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .cap_evt(cap_evt), .tmr_a(tmr_a), .tmr_b(tmr_b),
        .mode(mode), .tsel(tsel), .mode_wr(mode_wr), .cap_val(cap_val),
        .flag(flag), .rdata(reg_rdata)
    );

    // Interrupt request follows the sticky flag.
    always_comb cap_irq = flag;
endmodule

// File: rtl/ecap_chk.sv
// Checker: temporal properties of the capture unit, bound to the top.
module ecap_chk #(
    parameter int TMR_W = 16,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cap_evt,
    input logic             tsel,
    input logic [3:0]       mode,
    input logic [TMR_W-1:0] tmr_a,
    input logic [TMR_W-1:0] tmr_b,
    input logic [TMR_W-1:0] cap_val,
    input logic             flag,
    input logic             reg_wr,
    input logic [1:0]       reg_addr,
    input logic [CNT_W-1:0] presc_cnt
);
    AST_CAPTURE_LOADS_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> cap_val == ($past(tsel) ? $past(tmr_b) : $past(tmr_a))); // R2
    AST_FLAG_SET_ON_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> flag); // R9
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !(reg_wr && reg_addr == 2'd3)) |=> flag); // R9
    AST_CAPTURE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_evt && !(reg_wr && (reg_addr == 2'd1 || reg_addr == 2'd2))) |=> $stable(cap_val)); // R10
    AST_DISABLED_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[3:2] != 2'b01) |=> !cap_evt); // R7
    AST_COUNT_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd0) |=> presc_cnt == '0); // R6
endmodule

bind edge_capture_unit ecap_chk #(.TMR_W(TMR_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cap_evt(cap_evt), .tsel(tsel), .mode(mode),
    .tmr_a(tmr_a), .tmr_b(tmr_b), .cap_val(cap_val), .flag(flag),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .presc_cnt(presc_cnt)
);

// File: tb/edge_capture_unit_tb.sv
module edge_capture_unit_tb;
    localparam logic [15:0] KEY = 16'hA5C3;
    localparam int NROWS = 10;
    // Row: {mode[3:0], tsel, pulses[4:0]}
    localparam logic [9:0] VEC [NROWS] = '{
        {4'b0101, 1'b0, 5'd1},   // R4 single rise
        {4'b0100, 1'b0, 5'd2},   // R3 falls only, R10 overwrite
        {4'b0101, 1'b1, 5'd2},   // R8 timer B, R10
        {4'b0110, 1'b0, 5'd3},   // R5 three rises: nothing
        {4'b0110, 1'b0, 5'd4},   // R5 fourth rise captures
        {4'b0111, 1'b1, 5'd16},  // R5 sixteenth rise captures
        {4'b0111, 1'b0, 5'd15},  // R5 fifteen rises: nothing
        {4'b0000, 1'b0, 5'd2},   // R7 disabled low code
        {4'b1100, 1'b1, 5'd2},   // R7 disabled high code
        {4'b0100, 1'b1, 5'd1}    // R3 with timer B
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cap_pin = 1'b0;
    logic [15:0] cyc = 16'd0;
    logic [15:0] tmr_a, tmr_b;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [7:0]  reg_wdata = 8'd0;
    logic [7:0]  reg_rdata;
    logic        cap_irq;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // model state
    logic [3:0]  m_mode = 4'd0;
    logic        m_sel = 1'b0;
    int          m_cnt = 0;
    logic [15:0] m_cap = 16'd0;
    logic        m_flag = 1'b0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 16'd1;
    assign tmr_a = cyc;
    assign tmr_b = cyc ^ KEY;

    edge_capture_unit u_dut (
        .clk(clk), .rst_n(rst_n), .cap_pin(cap_pin), .tmr_a(tmr_a), .tmr_b(tmr_b),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .cap_irq(cap_irq)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        if (a == 2'd0) begin m_mode = d[3:0]; m_sel = d[4]; m_cnt = 0; end
        if (a == 2'd1) m_cap[7:0] = d;
        if (a == 2'd2) m_cap[15:8] = d;
        if (a == 2'd3) m_flag = d[0];
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic model_event(input logic [15:0] t);
        logic [15:0] v;
        v = t + 16'd3;
        m_cap = m_sel ? (v ^ KEY) : v;
        m_flag = 1'b1;
    endtask

    // Drive one pin level change and update the model.
    task automatic set_pin(input logic v);
        logic [15:0] t;
        @(negedge clk);
        cap_pin = v;
        t = cyc;
        if (v) begin
            if (m_mode == 4'b0101) model_event(t);
            else if (m_mode == 4'b0110 || m_mode == 4'b0111) begin
                if (m_cnt == ((m_mode == 4'b0110) ? 3 : 15)) begin
                    m_cnt = 0; model_event(t);
                end else m_cnt++;
            end
        end else if (m_mode == 4'b0100) model_event(t);
        repeat (6) @(negedge clk);
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            set_pin(1'b1);
            set_pin(1'b0);
        end
    endtask

    task automatic check_state(input string tag);
        logic [7:0] lo, hi, fl;
        rd(2'd1, lo);
        rd(2'd2, hi);
        rd(2'd3, fl);
        check({tag, " capture"}, {hi, lo}, m_cap);
        check({tag, " flag"}, {8'd0, fl}, {15'd0, m_flag});
        check({tag, " irq"}, {15'd0, cap_irq}, {15'd0, m_flag});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], d);
            check("R1 reset register", {8'd0, d}, 16'd0);
        end
        check("R1 reset irq", {15'd0, cap_irq}, 16'd0);

        // R11 direct byte writes and control readback
        wr(2'd1, 8'h34);
        wr(2'd2, 8'h12);
        check_state("R11 direct load");
        wr(2'd0, 8'h17);
        rd(2'd0, d);
        check("R11 control readback", {8'd0, d}, 16'h0017);

        // table walk: R2 R3 R4 R5 R7 R8 R10
        for (int r = 0; r < NROWS; r++) begin
            wr(2'd0, {3'd0, VEC[r][5], VEC[r][9:6]});
            wr(2'd3, 8'd0);
            pulses(int'(VEC[r][4:0]));
            check_state($sformatf("R2 table row %0d", r));
        end

        // R6 mode rewrite restarts the divide-by-4 count
        wr(2'd0, 8'h06);
        wr(2'd3, 8'd0);
        pulses(2);
        wr(2'd0, 8'h06);
        pulses(3);
        check_state("R6 after 2+3 rises");
        pulses(1);
        check_state("R6 fourth after rewrite");

        // R9 flag sticky, then cleared and set by software
        repeat (20) @(negedge clk);
        check_state("R9 sticky");
        wr(2'd3, 8'd0);
        check_state("R9 cleared");
        wr(2'd3, 8'd1);
        check_state("R9 software set");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule